// File: doc/BRIEF.md
# DRAM Compressed Parallel Test-Mode Logic

This block sits between the strobe and data pins of a four-bit-wide dynamic memory and a 16-bit internal column interface, where each I/O owns a group of four cells. It runs in the system clock domain. The RAS#, CAS# and WE# strobes are brought in through a configurable synchroniser. The block then classifies every row cycle by the levels of CAS# and WE# at the moment RAS# falls.

In normal mode the low column bits choose one cell in each group. A write lands in that one cell per I/O, and a read returns that one cell per I/O. A row cycle that opens with CAS# and WE# both already low switches the block into test mode. In test mode the low column bits have no effect. A write reaches all four cells behind each I/O at once. On a read, each output pin reports agreement: it is high when the four cells behind it hold equal values and low when they differ.

Two cycles leave test mode: a refresh that opens with CAS# low and WE# high, and a row cycle during which CAS# never falls. Ordinary read and write cycles keep the block in test mode, and so do repeated entry cycles. The per-I/O compare result of the latest test-mode read is held in a register, and the current mode is shown on its own output.

Top module: `dram_ptest_top`

## Requirements
- R1: After reset `test_mode` is 0, `cmp_flags` is all zeros, and `arr_we` and `arr_re` are 0.
- R2: A row cycle whose synchronised RAS# fall finds CAS# low and WE# low sets `test_mode` to 1.
- R3: A row cycle whose RAS# fall finds CAS# low and WE# high clears `test_mode`.
- R4: A row cycle that opens with CAS# high and ends (RAS# rises) without any CAS# low level clears `test_mode` at the RAS# rise.
- R5: Row cycles with a CAS# access (read or write) and repeated entry cycles leave `test_mode` unchanged.
- R6: In normal mode, internal cell index i*4+k belongs to I/O i, with cell k selected by `col_lo`. Bit i*4+`col_lo` of `arr_wmask` is set and all other bits are clear. Every cell of group i carries `wdata[i]` on `arr_wdata`.
- R7: In test mode `arr_wmask` is all ones, every cell of group i carries `wdata[i]`, and `col_lo` has no effect.
- R8: In normal mode `dout[i]` equals `arr_rdata[i*4+col_lo]`.
- R9: In test mode `dout[i]` is 1 when the four cells of group i are all 0 or all 1, and 0 otherwise. `col_lo` has no effect.
- R10: `arr_we` is 1 only while RAS# and CAS# are low in a cycle that opened with CAS# high, with WE# low. `arr_re` follows the same rule with WE# high. Refresh and entry cycles never assert either.
- R11: `cmp_flags` loads the test-mode compare result on each clock of a test-mode read and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| col_lo | input | 2 | Low column address bits (cell select) |
| wdata | input | 4 | Write data, one bit per I/O |
| arr_rdata | input | 16 | Cells read from the array, group i at bits i*4+3..i*4 |
| arr_wdata | output | 16 | Cell write data to the array |
| arr_wmask | output | 16 | Per-cell write enable mask |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe |
| dout | output | 4 | Read data or per-I/O agreement flag |
| test_mode | output | 1 | Current mode, 1 = compressed test mode |
| cmp_flags | output | 4 | Compare result of the latest test-mode read |

## Verification
The bench separates the two exits that look alike at the RAS# fall: a RAS#-only cycle and a normal access. A design that decided the mode at the fall alone would either never leave test mode on a RAS#-only refresh or drop out of it on every ordinary read. Reads in test mode are driven with groups that are all 0, all 1 and mixed, and with every `col_lo` value. A design that honoured the low column bits in test mode, or that reduced a group with AND instead of an agreement test, would report wrong pass flags. Repeated entry cycles and CBR refreshes done in normal mode are also covered, where a design that toggled the mode or exited wrongly would show a wrong `test_mode`.

// File: rtl/dram_ptest_pkg.sv
package dram_ptest_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE    = 2'd0,
      CYC_ACCESS  = 2'd1,
      CYC_REFRESH = 2'd2
   } cyc_e;
endpackage

// File: rtl/dram_strobe_sync.sv
module dram_strobe_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dram_strobe_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '1;
         else if (s == 0) stg[s] <= d;
         else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dram_mode_ctl.sv
module dram_mode_ctl
   import dram_ptest_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ras_s,
   input  logic cas_s,
   input  logic we_s,
   output logic test_mode,
   output cyc_e cls
);
   logic ras_d;
   logic cas_seen;
   logic ras_fall;
   logic ras_rise;

   assign ras_fall = ras_d & ~ras_s;
   assign ras_rise = ~ras_d & ras_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_d     <= 1'b1;
         cls       <= CYC_IDLE;
         cas_seen  <= 1'b0;
         test_mode <= 1'b0;
      end else begin
         ras_d <= ras_s;
         if (ras_fall) begin
            cas_seen <= 1'b0;
            if (!cas_s) begin
               cls       <= CYC_REFRESH;
               test_mode <= ~we_s;
            end else begin
               cls <= CYC_ACCESS;
            end
         end else if (ras_rise) begin
            cls <= CYC_IDLE;
            if (cls == CYC_ACCESS && !cas_seen)
               test_mode <= 1'b0;
         end else if (cls == CYC_ACCESS && !cas_s) begin
            cas_seen <= 1'b1;
         end
      end
   end

   assert_wcbr_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ras_fall && !cas_s && !we_s |=> test_mode);
   assert_cbr_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ras_fall && !cas_s && we_s |=> !test_mode);
   assert_ras_only_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ras_rise && cls == CYC_ACCESS && !cas_seen |=> !test_mode);
   assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_fall && !ras_rise |=> $stable(test_mode));
endmodule

// File: rtl/dram_lane_mux.sv
module dram_lane_mux #(
   parameter int IO_W  = 4,
   parameter int CELLS = 4,
   localparam int SEL_W = $clog2(CELLS),
   localparam int ARR_W = IO_W * CELLS
) (
   input  logic             test_mode,
   input  logic [SEL_W-1:0] col_lo,
   input  logic [IO_W-1:0]  wdata,
   input  logic [ARR_W-1:0] arr_rdata,
   output logic [ARR_W-1:0] arr_wdata,
   output logic [ARR_W-1:0] arr_wmask,
   output logic [IO_W-1:0]  dout,
   output logic [IO_W-1:0]  agree
);
   if (CELLS < 2 || (1 << SEL_W) != CELLS) begin : g_bad_cells
      $error("dram_lane_mux: CELLS must be a power of two, at least 2");
   end

   for (genvar i = 0; i < IO_W; i++) begin : g_io
      logic [CELLS-1:0] grp;
      logic [CELLS-1:0] sel;
      assign grp = arr_rdata[i*CELLS +: CELLS];
      assign sel = test_mode ? {CELLS{1'b1}} : (CELLS'(1) << col_lo);
      assign arr_wdata[i*CELLS +: CELLS] = {CELLS{wdata[i]}};
      assign arr_wmask[i*CELLS +: CELLS] = sel;
      assign agree[i] = (&grp) | ~(|grp);
      assign dout[i]  = test_mode ? agree[i] : grp[col_lo];
   end
endmodule

// File: rtl/dram_ptest_top.sv
module dram_ptest_top
   import dram_ptest_pkg::*;
#(
   parameter int IO_W        = 4,
   parameter int CELLS       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W = $clog2(CELLS),
   localparam int ARR_W = IO_W * CELLS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [SEL_W-1:0] col_lo,
   input  logic [IO_W-1:0]  wdata,
   input  logic [ARR_W-1:0] arr_rdata,
   output logic [ARR_W-1:0] arr_wdata,
   output logic [ARR_W-1:0] arr_wmask,
   output logic             arr_we,
   output logic             arr_re,
   output logic [IO_W-1:0]  dout,
   output logic             test_mode,
   output logic [IO_W-1:0]  cmp_flags
);
   if (IO_W < 1) begin : g_bad_io
      $error("dram_ptest_top: IO_W must be at least 1");
   end

   logic [2:0]      strb_s;
   logic            ras_s, cas_s, we_s;
   cyc_e            cls;
   logic [IO_W-1:0] agree;
   logic            col_active;

   dram_strobe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n),
      .d ({ras_n, cas_n, we_n}), .q (strb_s)
   );
   assign {ras_s, cas_s, we_s} = strb_s;

   dram_mode_ctl u_mode (
      .clk (clk), .rst_n (rst_n),
      .ras_s (ras_s), .cas_s (cas_s), .we_s (we_s),
      .test_mode (test_mode), .cls (cls)
   );

   dram_lane_mux #(.IO_W(IO_W), .CELLS(CELLS)) u_lanes (
      .test_mode (test_mode), .col_lo (col_lo), .wdata (wdata),
      .arr_rdata (arr_rdata), .arr_wdata (arr_wdata),
      .arr_wmask (arr_wmask), .dout (dout), .agree (agree)
   );

   assign col_active = (cls == CYC_ACCESS) & ~ras_s & ~cas_s;
   assign arr_we = col_active & ~we_s;
   assign arr_re = col_active & we_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_flags <= '0;
      else if (test_mode && arr_re) cmp_flags <= agree;
   end

   assert_test_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |-> &arr_wmask);
   assert_norm_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |-> $countones(arr_wmask) == IO_W);
   assert_no_refresh_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cls != CYC_ACCESS |-> !arr_we && !arr_re);
   assert_cmp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(test_mode && arr_re) |=> $stable(cmp_flags));
endmodule

// File: tb/dram_ptest_top_test.sv
module dram_ptest_top_test;
   localparam int IO_W  = 4;
   localparam int CELLS = 4;
   localparam int ARR_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]       col_lo = '0;
   logic [IO_W-1:0]  wdata = '0;
   logic [ARR_W-1:0] arr_rdata = '0;
   logic [ARR_W-1:0] arr_wdata, arr_wmask;
   logic             arr_we, arr_re, test_mode;
   logic [IO_W-1:0]  dout, cmp_flags;

   int checks = 0;
   int errors = 0;
   logic exp_mode = 1'b0;
   logic [IO_W-1:0] exp_cmp = '0;

   always #2.5 clk = ~clk;

   dram_ptest_top uut (
      .clk (clk), .rst_n (rst_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
      .col_lo (col_lo), .wdata (wdata), .arr_rdata (arr_rdata),
      .arr_wdata (arr_wdata), .arr_wmask (arr_wmask), .arr_we (arr_we),
      .arr_re (arr_re), .dout (dout), .test_mode (test_mode), .cmp_flags (cmp_flags)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [ARR_W-1:0] f_mask(input logic tm, input logic [1:0] c);
      logic [ARR_W-1:0] m = '0;
      for (int i = 0; i < IO_W; i++)
         for (int k = 0; k < CELLS; k++)
            m[i*CELLS+k] = tm ? 1'b1 : (k == int'(c));
      return m;
   endfunction

   function automatic logic [ARR_W-1:0] f_wdata(input logic [IO_W-1:0] w);
      logic [ARR_W-1:0] d;
      for (int i = 0; i < IO_W; i++)
         for (int k = 0; k < CELLS; k++) d[i*CELLS+k] = w[i];
      return d;
   endfunction

   function automatic logic [IO_W-1:0] f_agree(input logic [ARR_W-1:0] r);
      logic [IO_W-1:0] a;
      for (int i = 0; i < IO_W; i++) begin
         logic [3:0] g = r[i*CELLS +: CELLS];
         a[i] = (g == 4'h0) || (g == 4'hF);
      end
      return a;
   endfunction

   function automatic logic [IO_W-1:0] f_dout(input logic tm, input logic [1:0] c,
                                             input logic [ARR_W-1:0] r);
      logic [IO_W-1:0] o;
      if (tm) return f_agree(r);
      for (int i = 0; i < IO_W; i++) o[i] = r[i*CELLS + int'(c)];
      return o;
   endfunction

   // one refresh-type row cycle: CAS# low before RAS#
   task automatic cbr_cycle(input logic we_lvl);
      we_n = we_lvl; cas_n = 1'b0; wait_cyc(4);
      ras_n = 1'b0; wait_cyc(5);
      chk(we_lvl ? "R10 cbr no access" : "R10 wcbr no access", {arr_we, arr_re}, 2'b00);
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; wait_cyc(5);
      exp_mode = ~we_lvl;
   endtask

   task automatic ras_only_cycle();
      ras_n = 1'b0; wait_cyc(6);
      chk("R4 mode kept before RAS# rise", test_mode, exp_mode);
      chk("R10 ras-only no access", {arr_we, arr_re}, 2'b00);
      ras_n = 1'b1; wait_cyc(5);
      exp_mode = 1'b0;
   endtask

   task automatic access(input logic wr, input logic [1:0] c, input logic [IO_W-1:0] w,
                         input logic [ARR_W-1:0] r, input string rq);
      ras_n = 1'b0; wait_cyc(4);
      col_lo = c; wdata = w; arr_rdata = r; we_n = ~wr;
      cas_n = 1'b0; wait_cyc(5);
      if (wr) begin
         chk("R10 write strobe", {arr_we, arr_re}, 2'b10);
         chk(exp_mode ? "R7 wmask" : "R6 wmask", arr_wmask, f_mask(exp_mode, c));
         chk(exp_mode ? "R7 wdata" : "R6 wdata", arr_wdata, f_wdata(w));
      end else begin
         chk("R10 read strobe", {arr_we, arr_re}, 2'b01);
         chk(rq, dout, f_dout(exp_mode, c, r));
         if (exp_mode) exp_cmp = f_agree(r);
         chk("R11 cmp_flags", cmp_flags, exp_cmp);
      end
      cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1;
      arr_rdata = ~r; wait_cyc(5);
      chk("R11 cmp_flags hold", cmp_flags, exp_cmp);
      chk("R5 mode after access", test_mode, exp_mode);
   endtask

   initial begin
      void'($urandom(32'd1053));
      wait_cyc(3);
      chk("R1 test_mode reset", test_mode, 1'b0);
      chk("R1 cmp_flags reset", cmp_flags, 4'h0);
      chk("R1 strobes reset", {arr_we, arr_re}, 2'b00);
      rst_n = 1'b1; wait_cyc(3);

      // normal mode, every cell select
      for (int c = 0; c < 4; c++) begin
         access(1'b1, 2'(c), 4'hA ^ 4'(c), 16'h0, "R6");
         access(1'b0, 2'(c), 16'h1248 << c, 16'h1248 << c, "R8 normal read");
      end
      cbr_cycle(1'b1);
      chk("R3 cbr in normal stays normal", test_mode, 1'b0);

      cbr_cycle(1'b0);
      chk("R2 wcbr enters test mode", test_mode, 1'b1);
      access(1'b0, 2'd0, 4'h0, 16'hF0F0, "R9 all agree");
      access(1'b0, 2'd3, 4'h0, 16'h0F10, "R9 one group mixed");
      access(1'b0, 2'd1, 4'h0, 16'h8421, "R9 all mixed");
      access(1'b1, 2'd2, 4'h5, 16'h0, "R7");
      cbr_cycle(1'b0);
      chk("R5 repeated wcbr keeps test mode", test_mode, 1'b1);

      for (int n = 0; n < 40; n++) begin
         logic [ARR_W-1:0] r = 16'($urandom);
         if (n % 3 == 0) r = {r[15:12], 4'hF, r[7:4], 4'h0};
         access(1'($urandom), 2'($urandom), 4'($urandom), r,
                exp_mode ? "R9 test read" : "R8 normal read");
         if (n == 20) begin
            cbr_cycle(1'b1);
            chk("R3 cbr exits test mode", test_mode, 1'b0);
         end
      end

      cbr_cycle(1'b0);
      chk("R2 re-entry", test_mode, 1'b1);
      ras_only_cycle();
      chk("R4 ras-only exits test mode", test_mode, 1'b0);
      access(1'b0, 2'd2, 4'h0, 16'h0F0F, "R8 normal after ras-only exit");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule